// File: doc/BRIEF.md
# SPI Clock-Stop Serial Port

This block moves words between a parallel interface and a four-wire SPI link in clock-stop operation. Clock polarity is fixed at 0: each side launches its next data bit just after the rising serial clock edge and samples the incoming bit on the falling edge. A single shift engine serves both roles. A run-time mode pin selects the role. As master, the block paces itself from a bit strobe supplied by an external divider. It drives the serial clock, an active-low select and the transmit line, and it samples the receive line. As slave, the block takes the serial clock and select from the link, re-times them into the core clock domain and uses them to drive the same engine.

The select line is active low on the pins and is treated internally as an active-high frame. The transmit line is driven only during a frame. It is released at the falling edge that closes the last bit, and a slave also releases it when its select is withdrawn. Words go out and come in most significant bit first. The word length is requested through a length input, and the block clamps that request to the range 8 to 32. Transmit words are accepted through a valid/ready handshake. Each received word lands in a holding register that keeps it until the consumer reads it, and an overrun flag records a word that replaced one still unread.

Top module: `spi_cs_port`

## Requirements
- R1: After reset, sel_n_o is 1, sclk_o is 0, sdo_oe is 0, tx_ready is 0, rx_valid is 0 and rx_overrun is 0.
- R2: In master mode (master_mode=1), a bit_tick pulse while idle with tx_valid=1 accepts the word: tx_ready is 1 for that cycle and sel_n_o falls on the next edge. The first rising edge of sclk_o follows one bit_tick later. sclk_o is never 1 while sel_n_o is 1.
- R3: Transmit data goes out most significant bit first. sdo_o changes only after a rising serial clock edge and holds that bit through the following falling edge.
- R4: Receive data is sampled on each falling serial clock edge, most significant bit first. The completed word appears on rx_data (right-aligned, upper bits 0) with rx_valid=1 on the edge after the last falling edge.
- R5: The effective word length is word_len clamped to the range 8..32. A request of 5 gives 8 bits, and a request of 45 gives 32 bits.
- R6: sdo_oe drops to 0 at the falling serial clock edge that samples the last bit of the word.
- R7: In master mode, sel_n_o returns to 1 exactly two bit_tick periods (one serial clock period) after the last falling edge of sclk_o.
- R8: In slave mode (master_mode=0), within 3 core cycles of sel_n_i falling, and before any serial clock edge, sdo_oe becomes 1 and sdo_o carries the most significant bit of the word. tx_ready pulses once if tx_valid=1. With tx_valid=0, a word of all zeros is sent and tx_ready stays 0.
- R9: In slave mode, the first rising edge of sclk_i leaves the first bit on sdo_o, and each later rising edge advances one bit. sclk_i and sel_n_i pass through a two-stage synchronizer, so each level must hold for at least 3 core cycles.
- R10: In slave mode, sel_n_i rising in the middle of a word sets sdo_oe to 0 within 3 core cycles and abandons the word, leaving rx_valid at 0.
- R11: rx_valid stays 1 until a cycle with rx_ready=1. A word that completes while rx_valid=1 and rx_ready=0 replaces rx_data and sets rx_overrun. A read handshake clears rx_overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = master, 0 = slave; change only between frames |
| word_len | input | 6 | Requested bits per word, clamped to 8..32 |
| bit_tick | input | 1 | Half-period strobe from the clock divider (master) |
| tx_data | input | 32 | Word to send, right-aligned |
| tx_valid | input | 1 | tx_data holds a word |
| tx_ready | output | 1 | Word taken this cycle |
| rx_data | output | 32 | Last received word, right-aligned |
| rx_valid | output | 1 | rx_data holds an unread word |
| rx_ready | input | 1 | Consumer reads rx_data this cycle |
| rx_overrun | output | 1 | An unread word was replaced |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sel_n_o | output | 1 | Active-low select driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| sel_n_i | input | 1 | Active-low select received in slave mode |
| sdi_i | input | 1 | Serial receive data |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Output enable of the transmit pad |

## Verification
The hardest case to reach from the ports is a slave frame withdrawn partway through a word. In that case the engine has to drop the pad and discard its partial word, even though the synchronized select edge can arrive while a clock edge is still in the synchronizer. The bench plays the external master bit by bit with its own timing. It raises select after three bits and then confirms that the pad is released, that no word was posted, and that the next full frame still starts from the first bit. Overrun is reached by running two master frames back to back with the read side held off.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_SETUP,
    M_HIGH,
    M_LOW,
    M_TAIL
  } mseq_e;

  // Requested word length forced into [lo, hi].
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/spi_cs_mseq.sv
module spi_cs_mseq
  import spi_cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic tx_valid,
  input  logic is_last,
  output logic sclk_o,
  output logic sel_n_o,
  output logic ev_start,
  output logic ev_rise,
  output logic ev_fall
);

  mseq_e st;
  logic  tail_q;

  always_comb begin
    ev_start = en && tick && (st == M_IDLE) && tx_valid;
    ev_rise  = tick && ((st == M_SETUP) || (st == M_LOW));
    ev_fall  = tick && (st == M_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      sclk_o  <= 1'b0;
      sel_n_o <= 1'b1;
      tail_q  <= 1'b0;
    end else if (tick) begin
      case (st)
        M_IDLE: begin
          if (en && tx_valid) begin
            st      <= M_SETUP;
            sel_n_o <= 1'b0;
          end
        end
        M_SETUP, M_LOW: begin
          st     <= M_HIGH;
          sclk_o <= 1'b1;
        end
        M_HIGH: begin
          sclk_o <= 1'b0;
          tail_q <= 1'b0;
          st     <= is_last ? M_TAIL : M_LOW;
        end
        M_TAIL: begin
          if (tail_q) begin
            st      <= M_IDLE;
            sel_n_o <= 1'b1;
          end else begin
            tail_q <= 1'b1;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R2: clock parked low while the slave is not selected
  p_idle_clock_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_o |-> !sclk_o);

  // R7: select is only released out of the tail phase
  p_tail_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n_o) |-> $past(st == M_TAIL));

endmodule

// File: rtl/spi_cs_ssync.sv
module spi_cs_ssync (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sclk_i,
  input  logic sel_n_i,
  input  logic sdi_i,
  output logic ev_start,
  output logic ev_abort,
  output logic ev_rise,
  output logic ev_fall,
  output logic sdi_s
);

  localparam int unsigned DEPTH = 3;

  logic [DEPTH-1:0] ck_q;
  logic [DEPTH-1:0] cs_q;
  logic [1:0]       di_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      cs_q <= '1;
      di_q <= '0;
    end else begin
      ck_q <= {ck_q[DEPTH-2:0], sclk_i};
      cs_q <= {cs_q[DEPTH-2:0], sel_n_i};
      di_q <= {di_q[0], sdi_i};
    end
  end

  logic sel_now;
  logic sel_was;
  assign sel_now = !cs_q[1];
  assign sel_was = !cs_q[2];

  assign ev_start = en && sel_now && !sel_was;
  assign ev_abort = en && !sel_now && sel_was;
  assign ev_rise  = en && sel_now && ck_q[1] && !ck_q[2];
  assign ev_fall  = en && sel_now && !ck_q[1] && ck_q[2];
  assign sdi_s    = di_q[1];

endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift #(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             early_oe,
  input  logic [MAX_W-1:0] tx_word,
  input  logic [LEN_W-1:0] len_eff,
  input  logic             launch,
  input  logic             sample,
  input  logic             abort,
  input  logic             sdi,
  output logic             sdo,
  output logic             oe,
  output logic             is_last,
  output logic             done,
  output logic [MAX_W-1:0] rx_word
);

  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_W);

  logic [MAX_W-1:0] tx_sh;
  logic [MAX_W-2:0] rx_sh;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic             active;
  logic             first;

  assign is_last = active && (cnt == len_q - 1'b1);
  assign done    = sample && is_last;
  assign rx_word = {rx_sh, sdi};
  assign sdo     = tx_sh[MAX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      cnt    <= '0;
      len_q  <= '0;
      active <= 1'b0;
      first  <= 1'b0;
      oe     <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
      oe     <= 1'b0;
    end else if (start) begin
      tx_sh  <= tx_word << (MAXL - len_eff);
      rx_sh  <= '0;
      cnt    <= '0;
      len_q  <= len_eff;
      active <= 1'b1;
      first  <= 1'b1;
      oe     <= early_oe;
    end else if (launch && active) begin
      // first rising edge re-launches the bit already on the line
      if (first) first <= 1'b0;
      else       tx_sh <= tx_sh << 1;
      oe <= 1'b1;
    end else if (sample && active) begin
      rx_sh <= rx_word[MAX_W-2:0];
      cnt   <= cnt + 1'b1;
      if (is_last) begin
        active <= 1'b0;
        oe     <= 1'b0;
      end
    end
  end

  // R6: the pad is released only by word completion or a withdrawn select
  p_oe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(done || abort));

  // R5: bit counter stays inside the latched word length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < len_q));

  // R9: no bit shift happens on the first launch of a frame
  p_first_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && active && first && !abort && !start) |=> $stable(tx_sh));

endmodule

// File: rtl/spi_cs_rxhold.sv
module spi_cs_rxhold #(
  parameter int unsigned MAX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [MAX_W-1:0] word,
  input  logic             rx_ready,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_valid,
  output logic             overrun
);

  logic take;
  logic lost;
  assign take = rx_valid && rx_ready;
  assign lost = rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      overrun  <= 1'b0;
    end else if (done) begin
      rx_data  <= word;
      rx_valid <= 1'b1;
      if (lost)      overrun <= 1'b1;
      else if (take) overrun <= 1'b0;
    end else if (take) begin
      rx_valid <= 1'b0;
      overrun  <= 1'b0;
    end
  end

  // R11: an unread word is held
  p_hold_unread_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R11: a word landing on an unread one flags overrun
  p_overrun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_valid && !rx_ready) |=> (overrun && rx_valid));

endmodule

// File: rtl/spi_cs_port.sv
module spi_cs_port
  import spi_cs_pkg::*;
#(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned MIN_W = 8,
  parameter int unsigned LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic [LEN_W-1:0] word_len,
  input  logic             bit_tick,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_overrun,
  output logic             sclk_o,
  output logic             sel_n_o,
  input  logic             sclk_i,
  input  logic             sel_n_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe
);

  logic [LEN_W-1:0] len_eff;
  assign len_eff = LEN_W'(clamp_len(32'(word_len), MIN_W, MAX_W));

  // named events of both role sequencers
  logic m_start, m_rise, m_fall;
  logic s_start, s_abort, s_rise, s_fall, s_sdi;
  logic ev_start, ev_launch, ev_sample, ev_abort, line_in;
  logic is_last, word_done;
  logic [MAX_W-1:0] word_in;

  spi_cs_mseq u_mseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (master_mode),
    .tick     (bit_tick),
    .tx_valid (tx_valid),
    .is_last  (is_last),
    .sclk_o   (sclk_o),
    .sel_n_o  (sel_n_o),
    .ev_start (m_start),
    .ev_rise  (m_rise),
    .ev_fall  (m_fall)
  );

  spi_cs_ssync u_ssync (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!master_mode),
    .sclk_i   (sclk_i),
    .sel_n_i  (sel_n_i),
    .sdi_i    (sdi_i),
    .ev_start (s_start),
    .ev_abort (s_abort),
    .ev_rise  (s_rise),
    .ev_fall  (s_fall),
    .sdi_s    (s_sdi)
  );

  assign ev_start  = master_mode ? m_start : s_start;
  assign ev_launch = master_mode ? m_rise  : s_rise;
  assign ev_sample = master_mode ? m_fall  : s_fall;
  assign ev_abort  = !master_mode && s_abort;
  assign line_in   = master_mode ? sdi_i   : s_sdi;
  assign word_in   = tx_valid ? tx_data : '0;
  assign tx_ready  = ev_start && tx_valid;

  spi_cs_shift #(
    .MAX_W (MAX_W),
    .LEN_W (LEN_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_start),
    .early_oe (!master_mode),
    .tx_word  (word_in),
    .len_eff  (len_eff),
    .launch   (ev_launch),
    .sample   (ev_sample),
    .abort    (ev_abort),
    .sdi      (line_in),
    .sdo      (sdo_o),
    .oe       (sdo_oe),
    .is_last  (is_last),
    .done     (word_done),
    .rx_word  (rx_word_w)
  );

  logic [MAX_W-1:0] rx_word_w;

  spi_cs_rxhold #(
    .MAX_W (MAX_W)
  ) u_rxhold (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (word_done),
    .word     (rx_word_w),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .overrun  (rx_overrun)
  );

  // R10: a withdrawn slave select releases the pad on the next edge
  p_slave_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && s_abort) |=> !sdo_oe);

  // R8: a slave frame drives the line from its start
  p_slave_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && s_start) |=> sdo_oe);

endmodule

// File: tb/spi_cs_port_bench.sv
module spi_cs_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_mode = 1'b1;
  logic [5:0]  word_len = 6'd8;
  logic        bit_tick;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        rx_overrun;
  logic        sclk_o, sel_n_o, sdo_o, sdo_oe;
  logic        sclk_s = 1'b0, sel_n_s = 1'b1, sdi_s = 1'b0, sdi_m = 1'b0;
  logic        sdi_i;

  assign sdi_i = master_mode ? sdi_m : sdi_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_port u_spi_cs_port (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .word_len(word_len),
    .bit_tick(bit_tick), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .sclk_o(sclk_o), .sel_n_o(sel_n_o), .sclk_i(sclk_s), .sel_n_i(sel_n_s),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  // divider model: one strobe every third cycle
  logic [1:0] tick_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else        tick_cnt <= (tick_cnt == 2'd2) ? 2'd0 : tick_cnt + 2'd1;
  end
  assign bit_tick = (tick_cnt == 2'd2);

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int eff_of(input int l);
    if (l < 8)  return 8;
    if (l > 32) return 32;
    return l;
  endfunction

  function automatic logic [31:0] mask_of(input int e);
    logic [63:0] m;
    m = (64'd1 << e) - 64'd1;
    return m[31:0];
  endfunction

  // master-side observers acting as the remote slave
  int          cur_eff = 8;
  logic [31:0] cur_pat = '0;
  logic [31:0] cap = '0;
  int          nfall = 0, nrise = 0, pidx = 0, viol = 0, nready = 0;
  time         t_selfall, t_firstrise, t_lastfall, t_selrise;

  always @(negedge sel_n_o) begin
    cap = '0; nfall = 0; nrise = 0; pidx = 0; t_selfall = $time;
  end
  always @(posedge sel_n_o) t_selrise = $time;
  always @(posedge sclk_o) begin
    if (nrise == 0) t_firstrise = $time;
    nrise++;
    sdi_m = (pidx < cur_eff) ? cur_pat[cur_eff-1-pidx] : 1'b0;
    pidx++;
  end
  always @(negedge sclk_o) begin
    cap = {cap[30:0], sdo_o};
    nfall++;
    t_lastfall = $time;
    #1;
    // R6: pad released exactly at the last falling edge
    check(sdo_oe == (nfall != cur_eff), "R6 oe at fall", 32'(sdo_oe),
          32'(nfall != cur_eff));
  end
  always @(posedge clk) begin
    if (sel_n_o && sclk_o) viol++;
    if (tx_ready) nready++;
  end

  task automatic m_xfer(input logic [5:0] lreq, input logic [31:0] tx,
                        input logic [31:0] pat);
    int e;
    e = eff_of(int'(lreq));
    cur_eff = e; cur_pat = pat;
    @(negedge clk);
    word_len = lreq; tx_data = tx; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    while (sel_n_o) @(negedge clk);
    while (!sel_n_o) @(negedge clk);
    check(cap == (tx & mask_of(e)), "R3 master tx bits", cap, tx & mask_of(e));
    check(nfall == e, "R5 bit count", 32'(nfall), 32'(e));
    check((t_firstrise - t_selfall) == 3*CLK_PERIOD, "R2 select lead",
          32'(t_firstrise - t_selfall), 32'(3*CLK_PERIOD));
    check((t_selrise - t_lastfall) == 6*CLK_PERIOD, "R7 select release",
          32'(t_selrise - t_lastfall), 32'(6*CLK_PERIOD));
  endtask

  task automatic read_rx;
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic slv_frame(input int e, input logic [31:0] din, input int nbits,
                           output logic [31:0] got, output logic e_oe,
                           output logic e_bit);
    got = '0;
    @(negedge clk) sel_n_s = 1'b0;
    repeat (HP) @(negedge clk);
    e_oe = sdo_oe; e_bit = sdo_o;
    for (int b = 0; b < nbits; b++) begin
      sclk_s = 1'b1; sdi_s = din[e-1-b];
      repeat (HP) @(negedge clk);
      got = {got[30:0], sdo_o};
      sclk_s = 1'b0;
      repeat (HP) @(negedge clk);
    end
  endtask

  // {requested length, transmit word, remote pattern}
  localparam logic [69:0] VECS [0:5] = '{
    {6'd8,  32'h0000_00A5, 32'h0000_003C},
    {6'd16, 32'h0000_BEEF, 32'h0000_1234},
    {6'd32, 32'hDEAD_BEEF, 32'h8001_7FFE},
    {6'd5,  32'h0000_00C3, 32'h0000_005A},
    {6'd45, 32'hF0F0_1234, 32'h1357_9BDF},
    {6'd13, 32'h0000_1ABC, 32'h0000_0F0F}
  };

  initial begin
    #(CLK_PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic eo, eb;
    int r0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(sel_n_o == 1'b1, "R1 sel_n_o", 32'(sel_n_o), 32'd1);
    check(sclk_o == 1'b0 && sdo_oe == 1'b0, "R1 sclk/oe", {sclk_o, sdo_oe}, 32'd0);
    check(tx_ready == 1'b0 && rx_valid == 1'b0 && rx_overrun == 1'b0,
          "R1 handshakes", {tx_ready, rx_valid, rx_overrun}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // master vectors (R2..R7), R5 clamp in entries 3 and 4
    for (int i = 0; i < 6; i++) begin
      logic [5:0] l; logic [31:0] t, p; int e;
      l = VECS[i][69:64]; t = VECS[i][63:32]; p = VECS[i][31:0];
      e = eff_of(int'(l));
      m_xfer(l, t, p);
      check(rx_valid == 1'b1, "R4 rx_valid", 32'(rx_valid), 32'd1);
      check(rx_data == (p & mask_of(e)), "R4 master rx word", rx_data, p & mask_of(e));
      check(rx_overrun == 1'b0, "R11 no overrun", 32'(rx_overrun), 32'd0);
      read_rx();
      check(rx_valid == 1'b0, "R11 read clears valid", 32'(rx_valid), 32'd0);
    end
    check(viol == 0, "R2 clock low while deselected", 32'(viol), 32'd0);

    // R11 overrun: two words with no read
    m_xfer(6'd8, 32'h11, 32'h81);
    repeat (4) @(negedge clk);
    check(rx_valid == 1'b1 && rx_data == 32'h81, "R11 held word", rx_data, 32'h81);
    m_xfer(6'd8, 32'h22, 32'h7E);
    check(rx_overrun == 1'b1, "R11 overrun set", 32'(rx_overrun), 32'd1);
    check(rx_data == 32'h7E, "R11 replaced word", rx_data, 32'h7E);
    read_rx();
    check(rx_valid == 1'b0 && rx_overrun == 1'b0, "R11 read clears",
          {rx_valid, rx_overrun}, 32'd0);

    // slave mode
    @(negedge clk) master_mode = 1'b0;
    repeat (4) @(negedge clk);
    word_len = 6'd12; tx_data = 32'h0000_0ABC; tx_valid = 1'b1;
    r0 = nready;
    slv_frame(12, 32'h0000_05A3, 12, got, eo, eb);
    check(eo == 1'b1 && eb == 1'b1, "R8 early oe and MSB", {eo, eb}, 32'd3);
    check(nready - r0 == 1, "R8 tx_ready pulse", 32'(nready - r0), 32'd1);
    check(got == 32'h0000_0ABC, "R9 slave tx bits", got, 32'h0000_0ABC);
    repeat (HP) @(negedge clk);
    check(sdo_oe == 1'b0, "R6 slave release after last bit", 32'(sdo_oe), 32'd0);
    check(rx_valid && rx_data == 32'h0000_05A3, "R4 slave rx word", rx_data, 32'h0000_05A3);
    sel_n_s = 1'b1; tx_valid = 1'b0;
    repeat (HP) @(negedge clk);
    read_rx();

    // R8: no word offered sends zeros
    word_len = 6'd8; r0 = nready;
    slv_frame(8, 32'h0000_00C6, 8, got, eo, eb);
    check(got == 32'h0 && eb == 1'b0, "R8 zero word", got, 32'h0);
    check(nready == r0, "R8 no tx_ready", 32'(nready - r0), 32'd0);
    repeat (HP) @(negedge clk);
    check(rx_data == 32'h0000_00C6, "R4 slave rx 8-bit", rx_data, 32'h0000_00C6);
    sel_n_s = 1'b1;
    repeat (HP) @(negedge clk);
    read_rx();

    // R10: select withdrawn after three bits
    word_len = 6'd16; tx_data = 32'h0000_F00F; tx_valid = 1'b1;
    slv_frame(16, 32'h0000_FFFF, 3, got, eo, eb);
    check(sdo_oe == 1'b1, "R10 oe during frame", 32'(sdo_oe), 32'd1);
    sel_n_s = 1'b1; tx_valid = 1'b0;
    repeat (HP) @(negedge clk);
    check(sdo_oe == 1'b0, "R10 oe after withdraw", 32'(sdo_oe), 32'd0);
    check(rx_valid == 1'b0, "R10 no word posted", 32'(rx_valid), 32'd0);

    // recovery frame after the abort
    tx_data = 32'h0000_8421; tx_valid = 1'b1;
    slv_frame(16, 32'h0000_1F2E, 16, got, eo, eb);
    check(got == 32'h0000_8421, "R9 frame after abort", got, 32'h0000_8421);
    repeat (HP) @(negedge clk);
    check(rx_data == 32'h0000_1F2E && rx_valid, "R10 clean restart rx",
          rx_data, 32'h0000_1F2E);
    sel_n_s = 1'b1; tx_valid = 1'b0;
    repeat (HP) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule